// File: doc/BRIEF.md
# Quasi-Bidirectional Parallel Port

This block is a general-purpose parallel port for a small microcontroller core. It has no direction register. Each bit has one output latch. A latch bit at 0 switches on a strong pull-down, so the pad is driven low. A latch bit at 1 releases the pad. The pad then rests high through a weak pull-up, and an outside device may still pull it low. To make a bit an input, software writes 1 to it. A configuration input removes the internal pull-up, which gives open-drain behaviour: a released pad then floats.

The CPU has two read paths. The pin path returns the pad levels after a two-flop synchronizer. The latch path returns what was last written. Read-modify-write requests take their operand from the latch, never from the pad. They apply a word or single-bit operation and store the result back in the latch, so the result also reaches the pad. The read result is held in an output register, which changes only in a cycle that enables a read.

Top module: `qbd_port`

## Requirements
- R1: In a cycle with `rst` high, the latch is set to all ones and `rd_data` is cleared. After that edge, `pull_dn` is 0 and `pull_up` is all ones when `cfg_od` is 0.
- R2: With `wr_en` high, the latch loads `wr_data` at the clock edge. `pull_dn` is the bitwise inverse of the latch.
- R3: With `cfg_od` at 0, each `pull_up` bit is 1 exactly when its latch bit is 1.
- R4: With `cfg_od` at 1, `pull_up` is all zeros, so a released pad floats.
- R5: With `rd_pin_en` high, `rd_data` after the edge holds the pad levels that passed the two synchronizer stages. A pad change made after edge k is returned by a read at edge k+3, and not by a read at edge k+2.
- R6: With `rd_latch_en` high and `rd_pin_en` low, `rd_data` after the edge holds the latch value from before that edge. This is true even when the same cycle also writes the latch.
- R7: With `rmw_en` high and `wr_en` low, the latch is replaced by a function of the old latch value and `rmw_arg`. The function is chosen by `rmw_op`: 0 AND, 1 OR, 2 XOR, 3 invert, 4 increment (modulo 2^WIDTH), 5 decrement (modulo 2^WIDTH). Codes 9 to 15 leave the latch unchanged.
- R8: The bit operations act only on the bit indexed by `rmw_bit`: `rmw_op` 6 sets it, 7 clears it, 8 inverts it. All other latch bits keep their value in that cycle.
- R9: When `wr_en` and `rmw_en` are both high, the write wins and the latch takes `wr_data`.
- R10: With both read enables low, `rd_data` keeps its value. With both read enables high, the pin path is selected.
- R11: A released bit reads back the level that an external driver forces on the pad. A bit whose latch holds 0 reads back low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_od | input | 1 | 1 = open-drain, internal pull-up removed |
| wr_en | input | 1 | Write strobe for the latch |
| wr_data | input | WIDTH | Data to write into the latch |
| rmw_en | input | 1 | Read-modify-write strobe |
| rmw_op | input | 4 | Read-modify-write operation code |
| rmw_arg | input | WIDTH | Operand for the word operations |
| rmw_bit | input | IDXW | Bit index for the single-bit operations |
| rd_pin_en | input | 1 | Read the synchronized pad levels |
| rd_latch_en | input | 1 | Read the latch contents |
| pin_in | input | WIDTH | Pad levels as seen at the pins |
| pull_dn | output | WIDTH | Strong pull-down enable for each bit |
| pull_up | output | WIDTH | Weak pull-up enable for each bit |
| rd_data | output | WIDTH | Registered read result |

## Verification
A wrong latch bit is visible on `pull_dn` from the edge that stored it, with no delay. On `pull_up` it shows at the same time, unless open-drain mode is on. A synchronizer with the wrong depth shows as a pin read that returns the new level one edge too early or one edge too late. An operation that takes its operand from the pad instead of the latch is caught by the bench, because it keeps the pads and the latch deliberately different. A bit operation that touches a neighbouring bit shows as more than one `pull_dn` bit changing in a single edge.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_NOT  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_SETB = 4'd6,
    OP_CLRB = 4'd7,
    OP_CPLB = 4'd8
  } rmw_op_e;
endpackage

// File: rtl/qbd_alu.sv
module qbd_alu #(
  parameter int WIDTH = 8,
  parameter int IDXW  = 3
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] arg,
  input  logic [3:0]       op,
  input  logic [IDXW-1:0]  idx,
  output logic [WIDTH-1:0] res
);
  import qbd_pkg::*;

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] mask;

  always_comb begin
    mask = ONE << idx;
    case (rmw_op_e'(op))
      OP_AND:  res = cur & arg;
      OP_OR:   res = cur | arg;
      OP_XOR:  res = cur ^ arg;
      OP_NOT:  res = ~cur;
      OP_INC:  res = cur + ONE;
      OP_DEC:  res = cur - ONE;
      OP_SETB: res = cur | mask;
      OP_CLRB: res = cur & ~mask;
      OP_CPLB: res = cur ^ mask;
      default: res = cur;
    endcase
  end
endmodule

// File: rtl/qbd_sync.sv
module qbd_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qbd_port.sv
module qbd_port #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDXW       = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_od,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rmw_en,
  input  logic [3:0]       rmw_op,
  input  logic [WIDTH-1:0] rmw_arg,
  input  logic [IDXW-1:0]  rmw_bit,
  input  logic             rd_pin_en,
  input  logic             rd_latch_en,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pull_dn,
  output logic [WIDTH-1:0] pull_up,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] rmw_res;
  logic [WIDTH-1:0] pin_s;
  logic [WIDTH-1:0] rd_q;

  qbd_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_s)
  );

  qbd_alu #(.WIDTH(WIDTH), .IDXW(IDXW)) u_alu (
    .cur (latch_q),
    .arg (rmw_arg),
    .op  (rmw_op),
    .idx (rmw_bit),
    .res (rmw_res)
  );

  // Output latch: a plain write has priority over read-modify-write.
  always_ff @(posedge clk) begin
    if (rst)         latch_q <= '1;
    else if (wr_en)  latch_q <= wr_data;
    else if (rmw_en) latch_q <= rmw_res;
  end

  // Read register: the pin path wins over the latch path.
  always_ff @(posedge clk) begin
    if (rst)              rd_q <= '0;
    else if (rd_pin_en)   rd_q <= pin_s;
    else if (rd_latch_en) rd_q <= latch_q;
  end

  assign pull_dn = ~latch_q;
  assign pull_up = latch_q & {WIDTH{~cfg_od}};
  assign rd_data = rd_q;
endmodule

// File: rtl/qbd_port_chk.sv
module qbd_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_od,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic             rmw_en,
  input logic [3:0]       rmw_op,
  input logic             rd_pin_en,
  input logic             rd_latch_en,
  input logic [WIDTH-1:0] pull_dn,
  input logic [WIDTH-1:0] pull_up,
  input logic [WIDTH-1:0] rd_data
);
  a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pull_dn == '0 && rd_data == '0));

  a_r2_write_loads: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> pull_dn == ~$past(wr_data));

  a_r3_pullup_released: assert property (@(posedge clk) disable iff (rst)
    !cfg_od |-> pull_up == ~pull_dn);

  a_r4_open_drain: assert property (@(posedge clk) disable iff (rst)
    cfg_od |-> pull_up == '0);

  a_r6_latch_read: assert property (@(posedge clk) disable iff (rst)
    (rd_latch_en && !rd_pin_en) |=> rd_data == ~$past(pull_dn));

  a_r8_single_bit: assert property (@(posedge clk) disable iff (rst)
    (rmw_en && !wr_en && (rmw_op == 4'd6 || rmw_op == 4'd7 || rmw_op == 4'd8))
      |=> $countones(pull_dn ^ $past(pull_dn)) <= 1);

  a_r10_read_hold: assert property (@(posedge clk) disable iff (rst)
    (!rd_pin_en && !rd_latch_en) |=> $stable(rd_data));
endmodule

bind qbd_port qbd_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_od      (cfg_od),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rmw_en      (rmw_en),
  .rmw_op      (rmw_op),
  .rd_pin_en   (rd_pin_en),
  .rd_latch_en (rd_latch_en),
  .pull_dn     (pull_dn),
  .pull_up     (pull_up),
  .rd_data     (rd_data)
);

// File: tb/sim_qbd_port.sv
`timescale 1ns/1ps
module sim_qbd_port;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst = 1'b1, cfg_od = 1'b0, wr_en = 1'b0, rmw_en = 1'b0;
  logic         rd_pin_en = 1'b0, rd_latch_en = 1'b0;
  logic [W-1:0] wr_data = '0, rmw_arg = '0;
  logic [3:0]   rmw_op = '0;
  logic [2:0]   rmw_bit = '0;
  logic [W-1:0] pin_in, pull_dn, pull_up, rd_data;
  logic [W-1:0] ext_en = '0, ext_val = '0;
  logic         float_lvl = 1'b0;

  int checks = 0, errors = 0;
  bit done = 0;

  qbd_port u0 (
    .clk(clk), .rst(rst), .cfg_od(cfg_od), .wr_en(wr_en), .wr_data(wr_data),
    .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_arg(rmw_arg), .rmw_bit(rmw_bit),
    .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en), .pin_in(pin_in),
    .pull_dn(pull_dn), .pull_up(pull_up), .rd_data(rd_data)
  );

  // Pad model: strong low, then external driver, then weak pull-up, else float.
  always_comb begin
    for (int i = 0; i < W; i++) begin
      if (pull_dn[i])      pin_in[i] = 1'b0;
      else if (ext_en[i])  pin_in[i] = ext_val[i];
      else if (pull_up[i]) pin_in[i] = 1'b1;
      else                 pin_in[i] = float_lvl;
    end
  end

  // Behavioural reference model.
  logic [W-1:0] m_latch, m_rd, pin_neg;
  logic [W-1:0] m_sync [$];
  bit m_valid = 0;

  function automatic logic [W-1:0] model_rmw(logic [W-1:0] cur, logic [W-1:0] arg,
                                             int op, int bit_ix);
    int v = int'(cur);
    case (op)
      0: return cur & arg;
      1: return cur | arg;
      2: return cur ^ arg;
      3: return ~cur;
      4: return W'((v + 1) % (1 << W));
      5: return W'((v + (1 << W) - 1) % (1 << W));
      6: begin cur[bit_ix] = 1'b1; return cur; end
      7: begin cur[bit_ix] = 1'b0; return cur; end
      8: begin cur[bit_ix] = ~cur[bit_ix]; return cur; end
      default: return cur;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_latch = '1; m_rd = '0; m_sync = '{'0, '0}; m_valid = 1;
    end else begin
      if (rd_pin_en)        m_rd = m_sync[1];
      else if (rd_latch_en) m_rd = m_latch;
      m_sync.push_front(pin_neg);
      void'(m_sync.pop_back());
      if (wr_en)       m_latch = wr_data;
      else if (rmw_en) m_latch = model_rmw(m_latch, rmw_arg, int'(rmw_op), int'(rmw_bit));
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_valid) begin
      chk("R2 pull_dn", pull_dn, ~m_latch);
      chk(cfg_od ? "R4 pull_up" : "R3 pull_up", pull_up, cfg_od ? '0 : m_latch);
      chk("R5 rd_data", rd_data, m_rd);
    end
    pin_neg = pin_in;
  end

  task automatic tick();
    @(posedge clk); #1;
    wr_en = 0; rmw_en = 0; rd_pin_en = 0; rd_latch_en = 0;
  endtask
  task automatic do_wr(logic [W-1:0] d);
    wr_en = 1; wr_data = d; tick();
  endtask
  task automatic do_rmw(int op, logic [W-1:0] a, int b);
    rmw_en = 1; rmw_op = 4'(op); rmw_arg = a; rmw_bit = 3'(b); tick();
  endtask
  task automatic rd_latch();
    rd_latch_en = 1; tick();
  endtask
  task automatic rd_pin();
    rd_pin_en = 1; tick();
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(2); rst = 0;
    chk("R1 pull_dn", pull_dn, 8'h00);
    chk("R1 pull_up", pull_up, 8'hFF);
    chk("R1 rd_data", rd_data, 8'h00);

    do_wr(8'h55); chk("R2 pull_dn", pull_dn, 8'hAA);
    chk("R3 pull_up", pull_up, 8'h55);
    rd_latch(); chk("R6 read", rd_data, 8'h55);

    // R6: a write in the same cycle as a latch read returns the old value
    wr_en = 1; wr_data = 8'h3C; rd_latch_en = 1; tick();
    chk("R6 old value", rd_data, 8'h55);
    rd_latch(); chk("R6 new value", rd_data, 8'h3C);

    // R7 word operations; pads held low externally to differ from the latch
    ext_en = 8'hFF; ext_val = 8'h00;
    do_rmw(0, 8'h0F, 0); rd_latch(); chk("R7 AND", rd_data, 8'h0C);
    do_rmw(1, 8'h30, 0); rd_latch(); chk("R7 OR", rd_data, 8'h3C);
    do_rmw(2, 8'hFF, 0); rd_latch(); chk("R7 XOR", rd_data, 8'hC3);
    do_rmw(3, 8'h00, 0); rd_latch(); chk("R7 NOT", rd_data, 8'h3C);
    do_wr(8'hFF);
    do_rmw(4, 8'h00, 0); rd_latch(); chk("R7 INC wrap", rd_data, 8'h00);
    do_rmw(5, 8'h00, 0); rd_latch(); chk("R7 DEC wrap", rd_data, 8'hFF);
    do_rmw(12, 8'h00, 0); rd_latch(); chk("R7 unused code", rd_data, 8'hFF);

    // R8 single-bit operations
    do_rmw(7, 8'h00, 3); chk("R8 clear bit3", pull_dn, 8'h08);
    do_rmw(8, 8'hFF, 0); rd_latch(); chk("R8 invert bit0", rd_data, 8'hF6);
    do_rmw(6, 8'h00, 3); rd_latch(); chk("R8 set bit3", rd_data, 8'hFE);
    do_rmw(7, 8'hFF, 7); rd_latch(); chk("R8 clear bit7", rd_data, 8'h7E);

    // R9: write wins over read-modify-write
    wr_en = 1; wr_data = 8'h12; rmw_en = 1; rmw_op = 4'd1; rmw_arg = 8'h80; tick();
    rd_latch(); chk("R9 write wins", rd_data, 8'h12);

    // R5 synchronizer latency
    do_wr(8'hFF); ext_en = 8'hFF; ext_val = 8'h00; idle(4);
    ext_val = 8'hFF; rd_pin(); chk("R5 edge1 old", rd_data, 8'h00);
    rd_pin(); chk("R5 edge2 old", rd_data, 8'h00);
    rd_pin(); chk("R5 edge3 new", rd_data, 8'hFF);

    // R11 external drive and low latch bits
    ext_val = 8'hA5; idle(3); rd_pin(); chk("R11 external level", rd_data, 8'hA5);
    ext_val = 8'hFF; do_wr(8'h0F); idle(3); rd_pin(); chk("R11 latch zero reads low", rd_data, 8'h0F);

    // R10 hold and both enables
    idle(2); chk("R10 hold", rd_data, 8'h0F);
    do_wr(8'hFF); ext_val = 8'h5A; idle(3);
    rd_pin_en = 1; rd_latch_en = 1; tick(); chk("R10 pin wins", rd_data, 8'h5A);

    // R4 open drain: released pads float
    ext_en = 8'h00; cfg_od = 1; tick();
    chk("R4 no pull-up", pull_up, 8'h00);
    idle(3); rd_pin(); chk("R4 floating pads", rd_data, 8'h00);
    cfg_od = 0; idle(3); rd_pin(); chk("R3 pulled high", rd_data, 8'hFF);

    // R1 reset in mid-run
    do_wr(8'h00); rst = 1; tick(); rst = 0;
    chk("R1 latch reset", pull_dn, 8'h00);
    chk("R1 rd reset", rd_data, 8'h00);
    idle(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule